// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog built around a down counter that software must service. The first time the counter reaches zero after the watchdog is enabled, it raises a timeout interrupt and reloads from the load register. If that interrupt is still pending when the counter reaches zero a second time, and reset generation is enabled, the block issues a one-cycle system reset request. Software services the watchdog by clearing the interrupt before the second zero. A write-protection lock keeps stray writes from changing the configuration.

Software reaches the block through a simple synchronous port. A write happens on the clock edge where `wr_en` is high. A read is combinational from `addr` to `rdata`. The word addresses are: 0 load value, 1 current count (read only), 2 control, 3 interrupt clear (write only, any data), 4 raw status, 5 masked status, 6 lock. Control bit 0 enables the counter and the interrupt, bit 1 enables reset generation, and bit 2 sends the timeout to the non-maskable line instead of the normal one.

The control sequencer has four states:
- `ST_IDLE`: disabled, nothing pending.
- `ST_IDLE_PEND`: disabled with the interrupt still pending.
- `ST_RUN`: counting, nothing pending.
- `ST_PEND`: counting with the interrupt pending.

Its transitions are:
- enable: `ST_IDLE`→`ST_RUN` and `ST_IDLE_PEND`→`ST_PEND`, each preloading the counter.
- disable: `ST_RUN`→`ST_IDLE` and `ST_PEND`→`ST_IDLE_PEND`.
- first timeout: `ST_RUN`→`ST_PEND`.
- escalation: the timeout taken while in `ST_PEND`; it stays in `ST_PEND`, or moves to `ST_RUN` if a clear arrives in the same cycle.
- clear: `ST_PEND`→`ST_RUN` and `ST_IDLE_PEND`→`ST_IDLE`.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, control reads 0, the load value and the count read 0xFFFFFFFF, raw status, masked status and lock read 0, and `irq_o`, `nmi_o` and `sys_rst_o` are low.
- R2: If the load value is L and control bit 0 is written to 1 on clock edge E, the counter takes L on edge E+1 and then counts down by one per cycle. The timeout is taken on edge E+L+2, which sets raw status (address 4 reads 1) and reloads the count to L.
- R3: A timeout taken while the interrupt is pending, with control bit 1 set, drives `sys_rst_o` high for exactly the one cycle after that edge. With bit 1 clear, no reset request is made.
- R4: A write to address 3 clears the pending interrupt on its edge. Counting then continues without a reset request, and the next zero raises the interrupt again.
- R5: While the counter runs, a write of value V to address 0 loads V into the counter on that edge. Such a write never clears a pending interrupt.
- R6: When control bit 2 is 0, a pending, enabled interrupt drives `irq_o`. When bit 2 is 1, it drives `nmi_o` instead. The two lines are never high together.
- R7: Masked status is raw status ANDed with control bit 0. Disabling the watchdog while the interrupt is pending leaves raw status at 1 and drops masked status and both interrupt lines. A clear still empties raw status while disabled.
- R8: While disabled, the count holds its value. Enabling again preloads the counter from the load register on the following edge.
- R9: Writing the key 0xC0DE5AFE to address 6 unlocks the block, and any other value written there locks it. Address 6 reads 1 when locked and 0 when unlocked. While locked, writes to addresses 0, 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 3 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq_o | output | 1 | Maskable timeout interrupt |
| nmi_o | output | 1 | Non-maskable timeout interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Each expected result is due a fixed number of edges after the write that causes it. Counting from the enabling write on edge E:
- the preload lands on E+1;
- the first timeout lands on E+L+2;
- the escalation pulse appears after E+2L+3 and is gone after E+2L+4.

A clear or a load write takes effect on its own edge. The bench drives writes at the falling edge and samples one nanosecond after the chosen rising edge. It checks the cycle just before each due edge as well as the due edge itself, so a result that comes a cycle early or a cycle late fails. The load-value sweep repeats these exact-cycle checks for several small loads.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR = 3'd3;
    localparam logic [ADDR_W-1:0] A_RAW   = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LOCK  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IDLE_PEND,
        ST_RUN,
        ST_PEND
    } wd_state_e;

    typedef struct packed {
        logic nmi_sel;
        logic rst_en;
        logic en;
    } wd_ctrl_t;

    localparam int CTRL_W = $bits(wd_ctrl_t);
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload,
    input  logic [CNT_W-1:0] preload_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '1;
        else if (preload) cnt <= preload_val;
        else if (dec)     cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              raw,
    output logic [CNT_W-1:0]  load_q,
    output wd_ctrl_t          ctrl_q,
    output logic              lock_q,
    output logic              load_wr,
    output logic              clr_wr,
    output logic [CNT_W-1:0]  rdata
);
    localparam int PAD_W = CNT_W - CTRL_W;

    logic wr_open;
    logic ctrl_wr;

    assign wr_open = wr_en && !lock_q;
    assign load_wr = wr_open && (addr == A_LOAD);
    assign ctrl_wr = wr_open && (addr == A_CTRL);
    assign clr_wr  = wr_open && (addr == A_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            ctrl_q <= '0;
            lock_q <= 1'b0;
        end else begin
            if (load_wr) load_q <= wdata;
            if (ctrl_wr) ctrl_q <= wd_ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_en && addr == A_LOCK) lock_q <= (wdata != UNLOCK_KEY);
        end
    end

    always_comb begin
        case (addr)
            A_LOAD:  rdata = load_q;
            A_COUNT: rdata = cnt;
            A_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl_q};
            A_RAW:   rdata = {{(CNT_W-1){1'b0}}, raw};
            A_MASK:  rdata = {{(CNT_W-1){1'b0}}, raw & ctrl_q.en};
            A_LOCK:  rdata = {{(CNT_W-1){1'b0}}, lock_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wd_ctrl_t ctrl,
    input  logic     zero,
    input  logic     clr,
    input  logic     load_wr,
    output logic     preload,
    output logic     dec,
    output logic     running,
    output logic     raw,
    output logic     irq_o,
    output logic     nmi_o,
    output logic     sys_rst_o
);
    wd_state_e st, nxt;
    logic      enable_hit;
    logic      timeout;
    logic      escalate;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt        = st;
        enable_hit = 1'b0;
        timeout    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (ctrl.en) begin
                    nxt        = ST_RUN;
                    enable_hit = 1'b1;
                end
            end
            ST_IDLE_PEND: begin
                if (ctrl.en) begin
                    nxt        = ST_PEND;
                    enable_hit = 1'b1;
                end else if (clr) begin
                    nxt = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (!ctrl.en) begin
                    nxt = ST_IDLE;
                end else if (zero) begin
                    nxt     = ST_PEND;
                    timeout = 1'b1;
                end
            end
            ST_PEND: begin
                if (!ctrl.en) begin
                    nxt = ST_IDLE_PEND;
                end else if (zero) begin
                    timeout = 1'b1;
                    nxt     = clr ? ST_RUN : ST_PEND;
                end else if (clr) begin
                    nxt = ST_RUN;
                end
            end
        endcase
    end

    assign running  = (st == ST_RUN) || (st == ST_PEND);
    assign raw      = (st == ST_PEND) || (st == ST_IDLE_PEND);
    assign escalate = timeout && (st == ST_PEND) && ctrl.rst_en;
    assign preload  = enable_hit || timeout || (load_wr && running);
    assign dec      = running && ctrl.en;
    assign irq_o    = raw && ctrl.en && !ctrl.nmi_sel;
    assign nmi_o    = raw && ctrl.en &&  ctrl.nmi_sel;

    // registered reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_rst_o <= 1'b0;
        else        sys_rst_o <= escalate;
    end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              sys_rst_o
);
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] preload_val;
    wd_ctrl_t         ctrl_q;
    logic             lock_q;
    logic             load_wr;
    logic             clr_wr;
    logic             raw;
    logic             zero;
    logic             preload;
    logic             dec;
    logic             running;

    wdog_regs #(.CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .raw(raw), .load_q(load_q), .ctrl_q(ctrl_q),
        .lock_q(lock_q), .load_wr(load_wr), .clr_wr(clr_wr), .rdata(rdata)
    );

    // a load write in flight supplies the new value directly
    assign preload_val = load_wr ? wdata : load_q;

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .preload(preload), .preload_val(preload_val),
        .dec(dec), .cnt(cnt), .zero(zero)
    );

    wdog_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .zero(zero), .clr(clr_wr),
        .load_wr(load_wr), .preload(preload), .dec(dec), .running(running),
        .raw(raw), .irq_o(irq_o), .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
    );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq_o,
    input logic              nmi_o,
    input logic              sys_rst_o,
    input logic              raw,
    input logic              lock_q,
    input logic              running,
    input wd_ctrl_t          ctrl_q,
    input logic [CNT_W-1:0]  cnt
);
    p_rst_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);

    p_rst_needs_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> $past(raw && ctrl_q.rst_en));

    p_lines_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && nmi_o));

    p_line_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || nmi_o) |-> (raw && ctrl_q.en));

    p_locked_ctrl_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_en && addr == A_CTRL) |=> $stable(ctrl_q));

    p_idle_count_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_q.en) |=> $stable(cnt));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq_o(irq_o),
    .nmi_o(nmi_o), .sys_rst_o(sys_rst_o), .raw(raw), .lock_q(lock_q),
    .running(running), .ctrl_q(ctrl_q), .cnt(cnt)
);

// File: tb/wdog_two_stage_tb_top.sv
`timescale 1ns/10ps
module wdog_two_stage_tb_top;
    import wdog_pkg::*;

    localparam logic [31:0] KEY = 32'hC0DE_5AFE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq_o, nmi_o, sys_rst_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wdog_two_stage dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        addr = a;
        #0.1;
        v = rdata;
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_LOAD, v);  chk("R1 load", v, 32'hFFFF_FFFF);
        rd(A_COUNT, v); chk("R1 count", v, 32'hFFFF_FFFF);
        rd(A_RAW, v);   chk("R1 raw", v, 0);
        rd(A_MASK, v);  chk("R1 mask", v, 0);
        rd(A_LOCK, v);  chk("R1 lock", v, 0);
        chk("R1 lines", {29'b0, irq_o, nmi_o, sys_rst_o}, 0);

        // R2/R3 sweep over small loads, reset generation on
        for (int L = 1; L <= 6; L++) begin
            do_reset();
            wr(A_LOAD, L);
            wr(A_CTRL, 32'h3);                 // edge E
            step(L + 1);  chk("R2 irq early", irq_o, 0);
            step(1);      chk("R2 irq due", irq_o, 1);
            rd(A_RAW, v);   chk("R2 raw", v, 1);
            rd(A_COUNT, v); chk("R2 reload", v, L);
            step(L);      chk("R3 rst early", sys_rst_o, 0);
            step(1);      chk("R3 rst due", sys_rst_o, 1);
            step(1);      chk("R3 rst one cycle", sys_rst_o, 0);
        end

        // R6 NMI routing, R3 no reset without enable bit
        do_reset();
        wr(A_LOAD, 2);
        wr(A_CTRL, 32'h5);
        step(4);
        chk("R6 nmi", nmi_o, 1);
        chk("R6 irq quiet", irq_o, 0);
        for (int k = 0; k < 8; k++) begin
            step(1);
            chk("R3 no rst when disabled", sys_rst_o, 0);
        end

        // R4 clear before second zero
        do_reset();
        wr(A_LOAD, 3);
        wr(A_CTRL, 32'h3);                     // E
        step(5);      chk("R4 irq set", irq_o, 1);
        wr(A_CLEAR, 0);                        // E+6
        chk("R4 cleared", irq_o, 0);
        step(1);      chk("R4 no rst", sys_rst_o, 0);
        step(1);      chk("R4 irq not yet", irq_o, 0);
        step(1);      chk("R4 irq again", irq_o, 1);
        chk("R4 no rst at zero", sys_rst_o, 0);
        step(1);      chk("R4 no rst after", sys_rst_o, 0);

        // R5 load write while running
        do_reset();
        wr(A_LOAD, 20);
        wr(A_CTRL, 32'h1);
        step(4);
        wr(A_LOAD, 2);                         // W
        rd(A_COUNT, v); chk("R5 immediate load", v, 2);
        step(2);      chk("R5 irq early", irq_o, 0);
        step(1);      chk("R5 irq due", irq_o, 1);
        wr(A_LOAD, 7);
        chk("R5 load keeps pending", irq_o, 1);
        rd(A_LOAD, v); chk("R5 load value", v, 7);

        // R8 disable freezes, re-enable preloads
        do_reset();
        wr(A_LOAD, 10);
        wr(A_CTRL, 32'h1);
        step(5);
        wr(A_CTRL, 32'h0);
        step(3);
        rd(A_COUNT, v); chk("R8 frozen", v, 5);
        wr(A_CTRL, 32'h1);
        step(1);
        rd(A_COUNT, v); chk("R8 preload", v, 10);

        // R7 masking while disabled with pending interrupt
        do_reset();
        wr(A_LOAD, 1);
        wr(A_CTRL, 32'h1);
        step(3);
        rd(A_MASK, v); chk("R7 mask on", v, 1);
        wr(A_CTRL, 32'h0);
        step(1);
        rd(A_RAW, v);  chk("R7 raw kept", v, 1);
        rd(A_MASK, v); chk("R7 mask off", v, 0);
        chk("R7 irq off", irq_o, 0);
        wr(A_CLEAR, 0);
        rd(A_RAW, v);  chk("R7 clear while off", v, 0);

        // R9 lock behaviour
        do_reset();
        wr(A_LOCK, 0);
        rd(A_LOCK, v); chk("R9 locked", v, 1);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); chk("R9 ctrl ignored", v, 0);
        wr(A_LOAD, 5);
        rd(A_LOAD, v); chk("R9 load ignored", v, 32'hFFFF_FFFF);
        step(5);
        chk("R9 no irq", irq_o, 0);
        wr(A_LOCK, KEY);
        rd(A_LOCK, v); chk("R9 unlocked", v, 0);
        wr(A_LOAD, 1);
        wr(A_CTRL, 32'h1);
        step(3);
        chk("R9 irq pending", irq_o, 1);
        wr(A_LOCK, 32'h1);
        wr(A_CLEAR, 0);
        chk("R9 clear ignored", irq_o, 1);
        rd(A_RAW, v); chk("R9 raw kept", v, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule